// File: doc/BRIEF.md
# SDRAM Column Burst and Latency Engine

This block is a cycle-accurate, device-side model of the column path of a byte-wide synchronous DRAM with four banks. It decodes the command pins on each rising clock edge, keeps a row address for each bank and holds a run-time mode word. From that word it takes the burst length, the address ordering inside a burst, the read latency and whether writes burst or transfer a single location.

A READ or WRITE command starts a column burst. The column sequence is worked out from the start column, the burst length and the ordering. Read data leaves a small internal byte array, passes through a latency pipeline and appears on the output bus two or three cycles after the command. Write data is stored on the command edge and on each edge after it until the burst ends. A byte mask input stops a write beat from being stored and blanks read beats after a fixed delay. A new column command or a burst-stop command cuts a running burst short. Holding clock enable low freezes the whole block.

Top module: `sdram_col_engine`

## Requirements
- R1: After reset, dqOe and dqOut are 0 and the mode is burst length 1, sequential order, latency 2 and burst writes.
- R2: Commands are decoded from {csN,rasN,casN,weN} on a rising edge with cke high: 0000 mode set, 0011 row activate, 0101 read, 0100 write, 0110 burst stop; anything else does nothing. On a mode set, addr[2:0] gives the burst length (000=1, 001=2, 010=4, 011=8, 111=full page), addr[3] the order (1 = interleaved), addr[6:4] the latency (010=2, 011=3) and addr[9] single-location writes (1).
- R3: The first beat of a read issued on edge t is driven, with dqOe high, in the cycle after edge t+CL, and beat k in the cycle after edge t+CL+k.
- R4: A mode set with a reserved burst-length code (100, 101, 110) keeps the previous burst length, and a reserved latency code keeps the previous latency, while the other fields still update.
- R5: A read with burst length 1, 2, 4 or 8 drives exactly that many beats, and dqOe then falls.
- R6: In sequential order, beat k reads column B + ((S mod L) + k) mod L, where S is the start column, L the burst length and B = S - (S mod L).
- R7: In interleaved order, beat k reads column B + ((S mod L) XOR k).
- R8: A full-page burst walks upward through all 16 columns of the row in sequential order, wraps from 15 to 0 and runs until a burst stop or a new column command.
- R9: A write stores its first byte on the command edge and the next bytes on the following edges up to the burst length; with single-location writes set, only the byte on the command edge is stored, while reads keep the burst length.
- R10: A write beat with dqm high on its edge is not stored.
- R11: dqm high on edge e blanks (dqOe low, dqOut 0) the read beat that would be driven in the cycle after edge e+2.
- R12: A read, write or burst stop on edge t ends the running burst: read beats that would be fetched in the cycle after edge t or later are dropped, and no write-burst byte is stored on edge t or later.
- R13: Each of the four banks keeps its own activated row, and reads and writes address bank ba at that bank's row, so the same column in different banks or rows holds separate data.
- R14: An edge with cke low is ignored: no command, write or dqm is taken, and the outputs and burst state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (12) | Row, column or mode word |
| dqm | input | 1 | Byte mask for writes and reads |
| dqIn | input | DATA_W (8) | Write data |
| dqOut | output | DATA_W (8) | Read data, 0 when not driven |
| dqOe | output | 1 | High while a read beat is driven |

## Verification
The bench uses the default sizes: two row bits and four column bits, so each row holds 16 bytes and the whole array is 256 bytes. With a 16-column page, a full-page burst wraps from column 15 to 0 within a run of a few dozen cycles, and the bench fills whole rows before reading them back. Four rows per bank let row switching inside one bank and the same column in all four banks be checked. A 12-bit address bus leaves room for every mode field, including the reserved codes.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

  // Command codes on {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_MODE = 4'b0000;
  localparam logic [3:0] CMD_ACT  = 4'b0011;
  localparam logic [3:0] CMD_RD   = 4'b0101;
  localparam logic [3:0] CMD_WR   = 4'b0100;
  localparam logic [3:0] CMD_STOP = 4'b0110;

  localparam logic [2:0] BL_PAGE = 3'b111;
  localparam logic [2:0] CL_TWO  = 3'b010;
  localparam logic [2:0] CL_THREE = 3'b011;

  typedef struct packed {
    logic [2:0] blCode;
    logic       interleave;
    logic       cl3;
    logic       singleWrite;
  } mode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic adv;    // edge is taken (cke high)
    logic wrEn;   // store a byte this edge
    logic rdEn;   // fetch a read beat this cycle
    logic cl3;    // latency 3 selected
  } strobe_t;

endpackage

// File: rtl/sdram_col_ctrl.sv
module sdram_col_ctrl
  import sdram_col_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  localparam int BANKS = 1 << BA_W,
  localparam int IDX_W = BA_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx
);

  logic [3:0] cmd;
  logic isMode, isAct, isRd, isWr, isStop, newCol;
  logic unusedAddr;

  logic [ROW_W-1:0] rowQ [BANKS];
  logic             actQ, rdQ;
  logic [BA_W-1:0]  bankQ;
  logic [COL_W-1:0] startQ, cntQ;

  logic [COL_W-1:0] lenMask, wrMask, curMask, offs, genCol;
  logic             fullPage, lastBeat, burstWr;

  assign cmd    = {csN, rasN, casN, weN};
  assign isMode = cke && (cmd == CMD_MODE);
  assign isAct  = cke && (cmd == CMD_ACT);
  assign isRd   = cke && (cmd == CMD_RD);
  assign isWr   = cke && (cmd == CMD_WR);
  assign isStop = cke && (cmd == CMD_STOP);
  assign newCol = isRd || isWr || isStop;
  assign unusedAddr = ^addr;

  // Burst length as a wrap mask over the column bits
  always_comb begin
    case (mode.blCode)
      3'd0:    lenMask = '0;
      3'd1:    lenMask = COL_W'(1);
      3'd2:    lenMask = COL_W'(3);
      3'd3:    lenMask = COL_W'(7);
      default: lenMask = '1;
    endcase
  end

  assign fullPage = (mode.blCode == BL_PAGE);
  assign wrMask   = mode.singleWrite ? '0 : lenMask;
  assign curMask  = rdQ ? lenMask : wrMask;

  // Column of the current beat: wrap inside the aligned block
  assign offs     = (!mode.interleave || fullPage) ? (startQ + cntQ) : (startQ ^ cntQ);
  assign genCol   = (startQ & ~curMask) | (offs & curMask);
  assign lastBeat = !fullPage && (cntQ == curMask);
  assign burstWr  = cke && actQ && !rdQ && !newCol;

  assign strb.adv  = cke;
  assign strb.wrEn = isWr || burstWr;
  assign strb.rdEn = actQ && rdQ;
  assign strb.cl3  = mode.cl3;

  assign wrIdx = isWr ? {ba, rowQ[ba], addr[COL_W-1:0]} : {bankQ, rowQ[bankQ], genCol};
  assign rdIdx = {bankQ, rowQ[bankQ], genCol};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      actQ   <= 1'b0;
      rdQ    <= 1'b0;
      bankQ  <= '0;
      startQ <= '0;
      cntQ   <= '0;
      for (int b = 0; b < BANKS; b++) rowQ[b] <= '0;
    end else if (cke) begin
      if (isMode) begin
        if (addr[2:0] inside {3'd0, 3'd1, 3'd2, 3'd3, BL_PAGE}) mode.blCode <= addr[2:0];
        mode.interleave  <= addr[3];
        if (addr[6:4] == CL_TWO)   mode.cl3 <= 1'b0;
        if (addr[6:4] == CL_THREE) mode.cl3 <= 1'b1;
        mode.singleWrite <= addr[9];
      end
      if (isAct) rowQ[ba] <= addr[ROW_W-1:0];
      if (isRd) begin
        actQ   <= 1'b1;
        rdQ    <= 1'b1;
        bankQ  <= ba;
        startQ <= addr[COL_W-1:0];
        cntQ   <= '0;
      end else if (isWr) begin
        actQ   <= (wrMask != '0);
        rdQ    <= 1'b0;
        bankQ  <= ba;
        startQ <= addr[COL_W-1:0];
        cntQ   <= COL_W'(1);
      end else if (isStop) begin
        actQ   <= 1'b0;
      end else if (actQ) begin
        if (lastBeat) actQ <= 1'b0;
        else          cntQ <= cntQ + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdram_col_dp.sv
module sdram_col_dp
  import sdram_col_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int STAGES = 3,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              dqm,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dataQ [STAGES];
  logic [STAGES-1:0] validQ;
  logic [STAGES-1:0] maskQ;
  logic              beatOn;
  logic [DATA_W-1:0] beatData;

  always_ff @(posedge clk) begin
    if (strb.wrEn && !dqm) mem[wrIdx] <= dqIn;
  end

  // Read fetch pipeline and read-mask delay line, both frozen when cke is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      maskQ  <= '0;
      for (int i = 0; i < STAGES; i++) dataQ[i] <= '0;
    end else if (strb.adv) begin
      validQ <= {validQ[STAGES-2:0], strb.rdEn};
      maskQ  <= {maskQ[STAGES-2:0], dqm};
      dataQ[0] <= mem[rdIdx];
      for (int i = 1; i < STAGES; i++) dataQ[i] <= dataQ[i-1];
    end
  end

  assign beatOn   = strb.cl3 ? validQ[STAGES-1] : validQ[STAGES-2];
  assign beatData = strb.cl3 ? dataQ[STAGES-1]  : dataQ[STAGES-2];
  assign dqOe     = beatOn && !maskQ[STAGES-1];
  assign dqOut    = dqOe ? beatData : '0;

endmodule

// File: rtl/sdram_col_engine.sv
module sdram_col_engine
  import sdram_col_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int DATA_W = 8,
  localparam int IDX_W = BA_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  mode_t            modeW;
  strobe_t          strbW;
  logic [IDX_W-1:0] wrIdxW, rdIdxW;

  sdram_col_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .BA_W(BA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .mode(modeW), .strb(strbW), .wrIdx(wrIdxW), .rdIdx(rdIdxW)
  );

  sdram_col_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STAGES(3)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strbW), .wrIdx(wrIdxW), .rdIdx(rdIdxW),
    .dqm(dqm), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: rtl/sdram_col_chk.sv
module sdram_col_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic              dqm,
  input logic              dqOe,
  input logic [DATA_W-1:0] dqOut,
  input logic              wrStrobe,
  input logic [2:0]        blCode,
  input logic              singleWr
);

  logic [1:0] cyc;
  logic [3:0] cmdBits;
  assign cmdBits = {csN, rasN, casN, weN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R11: mask taken three edges back, carried over two taken edges, blanks the bus
  p_read_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && $past(dqm, 3) && $past(cke, 3) && $past(cke, 2) && $past(cke, 1)) |-> !dqOe);

  // R14: an edge with cke low leaves the outputs unchanged
  p_freeze_r14: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && !$past(cke)) |-> ($stable(dqOe) && $stable(dqOut)));

  // R9: in single-location write mode only the write command edge stores
  p_single_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && singleWr) |-> (cmdBits == 4'b0100));

  // R4: the held burst length never takes a reserved code
  p_bl_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (blCode != 3'b100 && blCode != 3'b101 && blCode != 3'b110));

  // R12: a burst stop ends a write burst on the next edge
  p_stop_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cke && cmdBits == 4'b0110) |=> (!wrStrobe || cmdBits == 4'b0100));

endmodule

bind sdram_col_engine sdram_col_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .dqm(dqm), .dqOe(dqOe), .dqOut(dqOut), .wrStrobe(strbW.wrEn),
  .blCode(modeW.blCode), .singleWr(modeW.singleWrite)
);

// File: tb/sdram_col_engine_tb.sv
module sdram_col_engine_tb;

  localparam int ROW_W = 2, COL_W = 4, ADDR_W = 12, BA_W = 2, DATA_W = 8;
  localparam int NROW = 1 << ROW_W;
  localparam int FULL = 1 << COL_W;
  localparam logic [3:0] C_NOP = 4'b0111, C_MODE = 4'b0000, C_ACT = 4'b0011;
  localparam logic [3:0] C_RD = 4'b0101, C_WR = 4'b0100, C_STOP = 4'b0110;

  logic clk = 1'b0, rstN = 1'b0, cke = 1'b1;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [BA_W-1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic dqm = 1'b0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [DATA_W-1:0] dqOut;
  logic dqOe;

  int checks = 0, errs = 0;
  string curReq = "R1";
  bit live = 0, done = 0;

  always #4 clk = ~clk;

  sdram_col_engine #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .BA_W(BA_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .dqm(dqm), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  // ---------------- behavioural reference ----------------
  int n;
  bit expV[int];
  int expD[int];
  int expS[int];
  bit maskAt[int];
  int refMem[int];
  int rows[4];
  int mBl, mCl, mInt, mSw;
  int wAct, wBank, wStart, wK, wLen;

  function automatic int blLen(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return FULL;
    endcase
  endfunction

  function automatic int colAt(int start, int k, int len, int inter);
    int base, off;
    if (len == FULL) return (start + k) % FULL;
    base = (start / len) * len;
    off  = start % len;
    if (inter != 0) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  function automatic int keyOf(int b, int r, int c);
    return (b * NROW + r) * FULL + c;
  endfunction

  always @(posedge clk) begin : refModel
    int cmdv, len, c, k, cl, bl, nb;
    int dropQ[$];
    if (!rstN) begin
      n = 0;
      expV.delete(); expD.delete(); expS.delete(); maskAt.delete();
      mBl = 0; mCl = 2; mInt = 0; mSw = 0;
      for (int b = 0; b < 4; b++) rows[b] = 0;
      wAct = 0;
    end else if (cke) begin
      n++;
      maskAt[n] = dqm;
      cmdv = {csN, rasN, casN, weN};
      if (cmdv == C_RD || cmdv == C_WR || cmdv == C_STOP) begin
        dropQ.delete();
        foreach (expS[t]) if (expS[t] >= n) dropQ.push_back(t);
        foreach (dropQ[i]) begin
          expV.delete(dropQ[i]); expD.delete(dropQ[i]); expS.delete(dropQ[i]);
        end
        wAct = 0;
      end else if (wAct != 0) begin
        c = colAt(wStart, wK, wLen, mInt);
        if (!dqm) refMem[keyOf(wBank, rows[wBank], c)] = dqIn;
        wK++;
        if (wLen != FULL && wK == wLen) wAct = 0;
      end
      case (cmdv)
        C_MODE: begin
          bl = addr[2:0];
          if (bl <= 3 || bl == 7) mBl = bl;
          mInt = addr[3];
          cl = addr[6:4];
          if (cl == 2 || cl == 3) mCl = cl;
          mSw = addr[9];
        end
        C_ACT: rows[ba] = addr[ROW_W-1:0];
        C_RD: begin
          len = blLen(mBl);
          nb = (len == FULL) ? 64 : len;
          for (int kk = 0; kk < nb; kk++) begin
            c = colAt(addr[COL_W-1:0], kk, len, mInt);
            k = keyOf(ba, rows[ba], c);
            expV[n + mCl + kk] = 1;
            expD[n + mCl + kk] = refMem.exists(k) ? refMem[k] : -1;
            expS[n + mCl + kk] = n + kk;
          end
        end
        C_WR: begin
          if (!dqm) refMem[keyOf(ba, rows[ba], addr[COL_W-1:0])] = dqIn;
          len = blLen(mBl);
          wLen = (mSw != 0) ? 1 : len;
          wStart = addr[COL_W-1:0];
          wBank = ba;
          wK = 1;
          wAct = (wLen > 1) ? 1 : 0;
        end
        default: ;
      endcase
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin : compare
    bit eOe;
    int eD;
    if (live && rstN && !done) begin
      eOe = expV.exists(n) && !(maskAt.exists(n - 2) && maskAt[n - 2]);
      eD  = eOe ? expD[n] : 0;
      checks++;
      if (dqOe !== eOe || dqOut !== DATA_W'(eD)) begin
        errs++;
        $display("FAIL %s cycle %0d: dqOe=%b dqOut=%h expected dqOe=%b dqOut=%h",
                 curReq, n, dqOe, dqOut, eOe, eD[7:0]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [3:0] c, input int b = 0, input int a = 0,
                       input logic m = 1'b0, input int d = 0, input logic k = 1'b1);
    {csN, rasN, casN, weN} = c;
    ba = BA_W'(b);
    addr = ADDR_W'(a);
    dqm = m;
    dqIn = DATA_W'(d);
    cke = k;
    @(negedge clk);
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) drive(C_NOP);
  endtask

  task automatic wrBurst(input int b, input int col, input int base, input int beats);
    drive(C_WR, b, col, 1'b0, base);
    for (int i = 1; i < beats; i++) drive(C_NOP, 0, 0, 1'b0, base + i);
  endtask

  task automatic rdGap(input int b, input int col, input int gap);
    drive(C_RD, b, col);
    idle(gap);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin : stim
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (dqOe !== 1'b0 || dqOut !== '0) begin
        errs++;
        $display("FAIL R1 reset: dqOe=%b dqOut=%h expected dqOe=0 dqOut=00", dqOe, dqOut);
      end
      @(negedge clk);
    end
    rstN = 1'b1;
    live = 1;
    idle(2);

    // R13: per-bank rows; R1: default mode is BL1, latency 2
    curReq = "R13";
    for (int b = 0; b < 4; b++) drive(C_ACT, b, b);
    for (int b = 0; b < 4; b++) drive(C_WR, b, 3, 1'b0, 8'hA0 + b);
    idle(1);
    curReq = "R1";
    rdGap(0, 3, 4);
    curReq = "R13";
    for (int b = 1; b < 4; b++) rdGap(b, 3, 3);
    drive(C_ACT, 0, 2);
    drive(C_WR, 0, 3, 1'b0, 8'h55);
    rdGap(0, 3, 4);
    drive(C_ACT, 0, 0);
    rdGap(0, 3, 4);
    rdGap(1, 3, 4);

    // R8: fill rows by full-page writes, then a wrapping full-page read
    curReq = "R8";
    drive(C_MODE, 0, 12'h027);
    wrBurst(0, 0, 8'h40, 16);
    drive(C_STOP);
    wrBurst(1, 0, 8'h80, 16);
    drive(C_STOP);
    rdGap(0, 14, 20);
    drive(C_STOP);
    idle(6);

    // R2, R3, R5: lengths and latencies
    curReq = "R5";
    drive(C_MODE, 0, 12'h033);
    rdGap(0, 0, 12);
    drive(C_MODE, 0, 12'h022);
    rdGap(0, 4, 8);
    curReq = "R3";
    drive(C_MODE, 0, 12'h031);
    rdGap(1, 6, 7);
    drive(C_MODE, 0, 12'h030);
    rdGap(1, 9, 6);
    curReq = "R2";
    drive(C_MODE, 0, 12'h020);
    drive(C_NOP, 0, 0);
    drive(4'b1101, 0, 5);     // deselected read: no effect
    rdGap(0, 5, 5);

    // R6: sequential wrap inside the aligned block
    curReq = "R6";
    drive(C_MODE, 0, 12'h023);
    rdGap(0, 5, 10);
    drive(C_MODE, 0, 12'h022);
    rdGap(1, 13, 6);

    // R7: interleaved order
    curReq = "R7";
    drive(C_MODE, 0, 12'h02B);
    rdGap(0, 5, 10);
    drive(C_MODE, 0, 12'h03A);
    rdGap(1, 6, 7);

    // R9: single-location writes, then burst writes
    curReq = "R9";
    drive(C_MODE, 0, 12'h222);
    wrBurst(0, 2, 8'hC2, 4);
    idle(1);
    rdGap(0, 0, 6);
    drive(C_MODE, 0, 12'h022);
    wrBurst(0, 8, 8'hE0, 4);
    idle(1);
    rdGap(0, 8, 6);

    // R10: masked write beat
    curReq = "R10";
    drive(C_WR, 0, 12, 1'b0, 8'hF0);
    drive(C_NOP, 0, 0, 1'b1, 8'hF1);
    drive(C_NOP, 0, 0, 1'b0, 8'hF2);
    drive(C_NOP, 0, 0, 1'b0, 8'hF3);
    idle(1);
    rdGap(0, 12, 6);

    // R11: read blanking two cycles after the mask
    curReq = "R11";
    drive(C_MODE, 0, 12'h033);
    drive(C_RD, 1, 0);
    drive(C_NOP);
    drive(C_NOP, 0, 0, 1'b1);
    drive(C_NOP, 0, 0, 1'b1);
    idle(10);

    // R12: truncation by a new read, a write and a burst stop
    curReq = "R12";
    drive(C_MODE, 0, 12'h023);
    rdGap(0, 0, 2);
    rdGap(1, 8, 3);
    wrBurst(0, 0, 8'h30, 2);
    drive(C_STOP, 0, 0, 1'b0, 8'h77);
    idle(2);
    rdGap(0, 0, 3);
    drive(C_STOP);
    idle(6);

    // R14: clock enable low freezes the block
    curReq = "R14";
    drive(C_RD, 1, 0);
    drive(C_NOP);
    repeat (3) drive(C_NOP, 0, 0, 1'b1, 0, 1'b0);
    idle(10);
    drive(C_MODE, 0, 12'h020);
    drive(C_WR, 0, 9, 1'b0, 8'h99, 1'b0);
    idle(2);
    rdGap(0, 9, 5);

    // R4: reserved codes keep the previous length and latency
    curReq = "R4";
    drive(C_MODE, 0, 12'h033);
    drive(C_MODE, 0, 12'h054);
    rdGap(1, 2, 13);

    finishRun();
  end

endmodule